// File: doc/BRIEF.md
# Dual-Rail Precharge Round Engine

This block runs a fixed iterative mixing function over a 64-bit word while carrying every data and key bit as a complementary pair of wires. The pair holds true on one wire and false on the other while it carries a value. Both wires go low during the spacer that separates two values. The same switching activity then occurs on every evaluation, whatever the data. Only the protected datapath uses the pair encoding: the state, the key and the round logic. The phase flag and the round counter are plain single-wire logic.

A single start pulse latches the input word and the key and encodes them into pairs. Sixteen rounds then follow. Each round is a spacer cycle and then an evaluation cycle, and each evaluation computes rotl(state XOR key, 7) using only monotone AND/OR terms on the pairs. A decoder at the edge of the datapath turns the final pair vector back into ordinary bits. It raises a done pulse and flags any code that breaks the pairing rules.

Top module: `dre_round_engine`

## Requirements
- R1: After synchronous reset `done_o`, `err_o` and `data_o` are all zero.
- R2: When a run completes, `data_o` holds x16, where x0 = `data_i` and x(n+1) = rotl(x(n) XOR `key_i`, 7). Here rotl moves bit i to bit (i+7) mod 64. `data_i` and `key_i` are sampled on the edge that accepts `start_i`.
- R3: `done_o` is high exactly 33 clock edges after the accepting edge (two cycles for each of 16 rounds, plus one decode cycle), and is low at every edge in between.
- R4: `done_o` is a one-cycle pulse, and `data_o` keeps its value after the pulse until the next run completes.
- R5: While a run is in progress, a `start_i` pulse and any change on `data_i` or `key_i` have no effect on the result or on the completion time.
- R6: On every spacer cycle, both wires of every pair in the round output register are low.
- R7: After every evaluation cycle, exactly one wire of each pair in the round output register is high, and the state register pairs are complementary for the whole run.
- R8: `err_o` stays low over runs made of valid pair codes. It would rise on a pair with both wires high, or with both low, during evaluation, and on any high wire during a spacer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run; ignored while one is in progress |
| data_i | input | 64 | Input word, sampled on the accepting edge |
| key_i | input | 64 | Round key, sampled on the accepting edge |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 64 | Decoded result, held until the next completion |
| err_o | output | 1 | Sticky invalid-code flag, cleared when a run starts |

## Verification
The hardest situation to reach from the ports is a start pulse, together with changed data and key values, that arrives in the middle of a run. It can land on a spacer cycle or on an evaluation cycle, and neither the result nor the completion time may change. The stimulus starts a run and then drives a conflicting start and new inputs in a chosen cycle of the 32-cycle window. That cycle varies across random and directed runs, so both the spacer and the evaluation slots are hit, and the last round is among them. The spacer and pairing rules are checked by assertions on the round register at every cycle.

// File: rtl/dre_pkg.sv
package dre_pkg;
  typedef enum logic [1:0] {
    WV_NONE = 2'd0,
    WV_PRE  = 2'd1,
    WV_EVAL = 2'd2
  } wave_kind_e;
endpackage

// File: rtl/dre_encode.sv
// Single-wire to pair converter; both wires stay low when not enabled.
module dre_encode #(
  parameter int W = 64
) (
  input  logic         en,
  input  logic [W-1:0] val,
  output logic [W-1:0] rail_t,
  output logic [W-1:0] rail_f
);
  always_comb begin
    rail_t = val  & {W{en}};
    rail_f = ~val & {W{en}};
  end
endmodule

// File: rtl/dre_xor_rot.sv
// Monotone pair XOR with the key followed by a fixed left rotation.
// With ev low, the gated inputs are all zero and so is the output.
module dre_xor_rot #(
  parameter int W   = 64,
  parameter int ROT = 7
) (
  input  logic         ev,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f
);
  localparam int RS = ROT % W;

  logic [W-1:0] ga_t, ga_f, gb_t, gb_f;
  logic [W-1:0] x_t, x_f;

  always_comb begin
    ga_t = a_t & {W{ev}};
    ga_f = a_f & {W{ev}};
    gb_t = b_t & {W{ev}};
    gb_f = b_f & {W{ev}};
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign x_t[i] = (ga_t[i] & gb_f[i]) | (ga_f[i] & gb_t[i]);
    assign x_f[i] = (ga_t[i] & gb_t[i]) | (ga_f[i] & gb_f[i]);
  end

  if (RS == 0) begin : g_norot
    assign y_t = x_t;
    assign y_f = x_f;
  end else begin : g_rot
    assign y_t = {x_t[W-1-RS:0], x_t[W-1:W-RS]};
    assign y_f = {x_f[W-1-RS:0], x_f[W-1:W-RS]};
  end
endmodule

// File: rtl/dre_decode.sv
// Pair to single-wire converter with code checking and registered outputs.
module dre_decode #(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  dre_pkg::wave_kind_e kind,
  input  logic                last,
  input  logic [W-1:0]        w_t,
  input  logic [W-1:0]        w_f,
  output logic [W-1:0]        data_o,
  output logic                done_o,
  output logic                err_o
);
  import dre_pkg::*;

  logic bad;

  always_comb begin
    bad = 1'b0;
    if (kind == WV_EVAL)
      bad = (|(w_t & w_f)) | (|(~(w_t | w_f)));
    else if (kind == WV_PRE)
      bad = |(w_t | w_f);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= (kind == WV_EVAL) && last;
      if ((kind == WV_EVAL) && last)
        data_o <= w_t;
      if (clr)
        err_o <= 1'b0;
      else if (bad)
        err_o <= 1'b1;
    end
  end

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    ((kind == WV_EVAL) && last) |=> done_o);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_no_code_error_R8: assert property (@(posedge clk) disable iff (rst)
    !err_o);
endmodule

// File: rtl/dre_round_engine.sv
module dre_round_engine #(
  parameter int W      = 64,
  parameter int ROUNDS = 16,
  parameter int ROT    = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  output logic         done_o,
  output logic [W-1:0] data_o,
  output logic         err_o
);
  import dre_pkg::*;

  localparam int CNT_W = $clog2(ROUNDS + 1);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  logic             busy, phase_ev, accept, wave_last;
  logic [CNT_W-1:0] cnt;
  wave_kind_e       wave_kind;
  logic [W-1:0]     st_t, st_f, ky_t, ky_f, wv_t, wv_f;
  logic [W-1:0]     ed_t, ed_f, ek_t, ek_f, rn_t, rn_f;

  assign accept = start_i & ~busy;

  dre_encode #(.W(W)) enc_data_i (.en(accept), .val(data_i), .rail_t(ed_t), .rail_f(ed_f));
  dre_encode #(.W(W)) enc_key_i  (.en(accept), .val(key_i),  .rail_t(ek_t), .rail_f(ek_f));

  dre_xor_rot #(.W(W), .ROT(ROT)) round_i (
    .ev(phase_ev), .a_t(st_t), .a_f(st_f), .b_t(ky_t), .b_f(ky_f),
    .y_t(rn_t), .y_f(rn_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      phase_ev  <= 1'b0;
      cnt       <= '0;
      wave_kind <= WV_NONE;
      wave_last <= 1'b0;
      st_t <= '0; st_f <= '0;
      ky_t <= '0; ky_f <= '0;
      wv_t <= '0; wv_f <= '0;
    end else begin
      wave_kind <= WV_NONE;
      wave_last <= 1'b0;
      if (accept) begin
        st_t <= ed_t; st_f <= ed_f;
        ky_t <= ek_t; ky_f <= ek_f;
        busy     <= 1'b1;
        phase_ev <= 1'b0;
        cnt      <= '0;
      end else if (busy) begin
        wv_t <= rn_t;
        wv_f <= rn_f;
        if (!phase_ev) begin
          wave_kind <= WV_PRE;
          phase_ev  <= 1'b1;
        end else begin
          wave_kind <= WV_EVAL;
          st_t      <= rn_t;
          st_f      <= rn_f;
          phase_ev  <= 1'b0;
          cnt       <= cnt + 1'b1;
          if (cnt == LAST_RND) begin
            busy      <= 1'b0;
            wave_last <= 1'b1;
          end
        end
      end
    end
  end

  dre_decode #(.W(W)) dec_i (
    .clk(clk), .rst(rst), .clr(accept),
    .kind(wave_kind), .last(wave_last), .w_t(wv_t), .w_f(wv_f),
    .data_o(data_o), .done_o(done_o), .err_o(err_o)
  );

  assert_spacer_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (wave_kind == WV_PRE) |-> ((wv_t == '0) && (wv_f == '0)));
  assert_eval_pairs_R7: assert property (@(posedge clk) disable iff (rst)
    (wave_kind == WV_EVAL) |-> (((wv_t & wv_f) == '0) && ((wv_t | wv_f) == '1)));
  assert_state_pairs_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st_t == ~st_f));
  assert_round_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(ROUNDS)));
  assert_phase_alternates_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept && (wave_last == 1'b0) && !phase_ev) |=> phase_ev);
endmodule

// File: tb/dre_round_engine_tb_top.sv
module dre_round_engine_tb_top;
  localparam int W      = 64;
  localparam int ROUNDS = 16;
  localparam int ROT    = 7;
  localparam int LAT    = 2 * ROUNDS + 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] din, kin;
  logic         done, err;
  logic [W-1:0] dout;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dre_round_engine #(.W(W), .ROUNDS(ROUNDS), .ROT(ROT)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .data_i(din), .key_i(kin),
    .done_o(done), .data_o(dout), .err_o(err)
  );

  function automatic logic [W-1:0] ref_fn(input logic [W-1:0] d, input logic [W-1:0] k);
    logic [W-1:0] x, v;
    x = d;
    for (int r = 0; r < ROUNDS; r++) begin
      v = x ^ k;
      x = (v << ROT) | (v >> (W - ROT));
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // poke: cycle index (1..32) where a conflicting start and new inputs are driven; 0 = none
  task automatic run_block(input logic [W-1:0] d, input logic [W-1:0] k, input int poke);
    logic [W-1:0] exp;
    int early;
    exp = ref_fn(d, k);
    early = 0;
    @(negedge clk);
    start = 1'b1; din = d; kin = k;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= LAT; i++) begin
      if (i == poke) begin
        start = 1'b1; din = ~d; kin = k ^ 64'h5A5A_0F0F_3C3C_9999;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (i < LAT && done) early++;
    end
    check(early == 0, "R3 done before latency", W'(early), '0);
    check(done == 1'b1, "R3 done at latency", W'(done), W'(1));
    check(dout == exp, poke != 0 ? "R5 result with mid-run start" : "R2 result", dout, exp);
    check(err == 1'b0, "R8 error flag", W'(err), '0);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R4 done pulse width", W'(done), '0);
    check(dout == exp, "R4 data held", dout, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd, rk;
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; start = 1'b0; din = '0; kin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(done == 1'b0, "R1 done after reset", W'(done), '0);
    check(err == 1'b0, "R1 err after reset", W'(err), '0);
    check(dout == '0, "R1 data after reset", dout, '0);

    // Directed corners (R2, R6, R7 via assertions)
    run_block('0, '0, 0);
    run_block('1, '0, 0);
    run_block('0, '1, 0);
    run_block(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0);
    run_block(64'h8000_0000_0000_0001, 64'h0000_0001_8000_0000, 0);
    // R5: conflicting start on a spacer slot, an evaluation slot, and the last round
    run_block(64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444, 1);
    run_block(64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444, 2);
    run_block(64'h0F0F_F0F0_AAAA_5555, 64'h7777_8888_9999_6666, 32);
    // Random runs, some with a mid-run poke
    for (int n = 0; n < 20; n++) begin
      rd = {$urandom(), $urandom()};
      rk = {$urandom(), $urandom()};
      run_block(rd, rk, (n % 2 == 0) ? 0 : (1 + int'($urandom_range(31))));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule